// File: doc/BRIEF.md
# Limit Interrupt Mode Logic

This block watches a set of voltage readings and two temperature readings. It compares each reading with limits that software has programmed and turns the results into latched status bits, one maskable system-management interrupt line, and a separate over-temperature line. Each reading is treated according to its own interrupt discipline.

Voltage channels use a re-arming window check. A voltage reading above its high limit or below its low limit sets that channel's bit. The bit stays set until software reads the status. The first temperature sensor switches to comparator behaviour when its hysteresis limit holds the largest positive code. The second temperature sensor has an explicit mode bit, and it also has a filter that counts consecutive faults before an event is recognised. The over-temperature line watches only the second sensor. It has its own limit pair, and it can run either as a comparator or as a latched interrupt.

The block sits after the converter and after the register decode. A converter strobe (`sample_stb`) marks each new set of readings. A one-cycle pulse (`stat_rd`) reports that software has read the status, which clears the latched events.

Top module: `lim_irq_top`

## Requirements
- R1: After a synchronous active-low reset, every `stat_o` bit, `smi_o` and `ovt_o` are 0.
- R2: On a cycle with `sample_stb` high, voltage bit i (`stat_o[i]`) is set when its reading is strictly above its high limit or strictly below its low limit. A reading equal to either limit does not set the bit.
- R3: A set voltage bit stays set until a `stat_rd` pulse clears it. If that channel is still outside its window, the next sample sets the bit again. When a sample that sets the bit coincides with a read, the bit ends up set.
- R4: When `t1_hyst` equals 127 (for an 8-bit width), temperature sensor 1 runs in comparator mode. Its bit, `stat_o[NUM_VOLT]`, follows whether the reading is above `t1_hi` at each sample, and `stat_rd` has no effect on it.
- R5: For any other `t1_hyst` value, sensor 1 runs in interrupt mode. A sample above `t1_hi` sets the bit only while the channel is armed, and setting the bit disarms the channel. `stat_rd` clears the bit. The channel re-arms only after a sample below `t1_hyst`.
- R6: With `t2_cmp_mode` equal to 1, sensor 2 (`stat_o[NUM_VOLT+1]`) runs in comparator mode. A qualified over-limit sample sets the bit, a sample below `t2_hyst` clears it, any other sample leaves it unchanged, and `stat_rd` has no effect.
- R7: With `t2_cmp_mode` equal to 0, sensor 2 follows the interrupt discipline of R5, using its own limit and hysteresis.
- R8: A sensor 2 over-limit condition (reading greater than `t2_hi`) qualifies only once it has been seen on `t2_fault_sel`+1 consecutive samples. A sample that is not over the limit restarts the count.
- R9: `ovt_o` compares `t2_rd` against `ovt_lim` and `ovt_hyst`, using the same fault count as R8. With `ovt_cmp_mode` equal to 1 it acts as a comparator as in R6. With `ovt_cmp_mode` equal to 0 it acts as a latched interrupt that `stat_rd` clears, as in R5.
- R10: `smi_o` is high exactly when some `stat_o` bit is set and its `smi_mask` bit is 0. A mask bit of 1 never changes `stat_o`.
- R11: `stat_o` and `ovt_o` change only at the clock edge that captures `sample_stb` or `stat_rd`. Readings that change with no strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | New readings valid this cycle |
| stat_rd | input | 1 | Status has been read; clears latched events |
| volt_rd | input | NUM_VOLT*W | Voltage readings, channel i in bits [i*W +: W] |
| volt_hi | input | NUM_VOLT*W | Voltage high limits |
| volt_lo | input | NUM_VOLT*W | Voltage low limits |
| t1_rd | input | W | Sensor 1 reading |
| t1_hi | input | W | Sensor 1 over limit |
| t1_hyst | input | W | Sensor 1 hysteresis; 127 selects comparator mode |
| t2_rd | input | W | Sensor 2 reading |
| t2_hi | input | W | Sensor 2 over limit |
| t2_hyst | input | W | Sensor 2 hysteresis |
| t2_cmp_mode | input | 1 | Sensor 2 discipline: 1 comparator, 0 interrupt |
| t2_fault_sel | input | CNT_W | Consecutive faults needed, minus one |
| ovt_lim | input | W | Over-temperature limit |
| ovt_hyst | input | W | Over-temperature hysteresis |
| ovt_cmp_mode | input | 1 | Over-temperature discipline: 1 comparator, 0 interrupt |
| smi_mask | input | NUM_VOLT+2 | Per-status mask; 1 blocks the bit from `smi_o` |
| stat_o | output | NUM_VOLT+2 | Status: voltages, then sensor 1, then sensor 2 |
| smi_o | output | 1 | Maskable interrupt request |
| ovt_o | output | 1 | Over-temperature output |

## Verification
The bench builds the block with two voltage channels, 8-bit readings and a 2-bit fault selector. With these values both sensor indices and a fault requirement of four consecutive samples can be reached in a few cycles. Two channels are enough to show that a mask bit hides one channel while a neighbouring channel stays unaffected. The 8-bit width puts the sensor 1 comparator code at 127, so that mode switch is exercised directly. A vector table follows one voltage channel, sensor 2 and the over-temperature line through window edges, the read-versus-sample race and the re-arm at hysteresis. Directed sequences then cover sensor 1's two modes, sensor 2's comparator mode, the longest fault filter, masking and readings that change with no strobe.

// File: rtl/lim_pkg.sv
// Package: shared discipline type and helpers for the limit interrupt logic.
// Assumes readings are unsigned codes of a common width.
package lim_pkg;

    typedef enum logic {
        DISC_INTR = 1'b0,   // latched event, cleared by status read
        DISC_CMP  = 1'b1    // level output with hysteresis
    } disc_e;

    // Convert a mode bit to the discipline type.
    function automatic disc_e disc_of(input logic cmp_bit);
        return cmp_bit ? DISC_CMP : DISC_INTR;
    endfunction

endpackage

// File: rtl/lim_volt_chan.sv
// Voltage window channel. Sets a sticky flag when a sampled reading
// leaves the [lo, hi] window; a status read clears it. A set on the
// same cycle as a read wins. Assumes lo <= hi.
module lim_volt_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample_stb,
    input  logic         clr_rd,
    input  logic [W-1:0] rd,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    output logic         flag_o
);

    logic outside;

    // Window test on the current reading.
    always_comb outside = (rd > hi) || (rd < lo);

    // Sticky flag: set by sampled excursion, cleared by read.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_o <= 1'b0;
        else if (sample_stb && outside) flag_o <= 1'b1;
        else if (clr_rd)                flag_o <= 1'b0;
    end

endmodule

// File: rtl/lim_fault_filter.sv
// Consecutive-fault filter. Qualifies an over-limit condition only once
// it has been seen on need_sel+1 consecutive samples. Non-sample cycles
// hold the count. The count saturates at the requirement.
module lim_fault_filter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic             over,
    input  logic [CNT_W-1:0] need_sel,
    output logic             hot_o
);

    localparam int CW = CNT_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] need;
    logic [CW-1:0] cnt_inc;

    // Requirement and incremented count.
    always_comb begin
        need    = {1'b0, need_sel} + CW'(1);
        cnt_inc = cnt_q + CW'(1);
        hot_o   = sample_stb && over && (cnt_inc >= need);
    end

    // Count consecutive over-limit samples, restart on a clean one.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (sample_stb) begin
            if (!over)                cnt_q <= '0;
            else if (cnt_inc >= need) cnt_q <= need;
            else                      cnt_q <= cnt_inc;
        end
    end

endmodule

// File: rtl/lim_temp_chan.sv
// Temperature channel with selectable discipline. In comparator mode the
// flag follows qualified over-limit samples and drops below hysteresis.
// In interrupt mode a qualified sample sets the flag once per arming.
// A read clears the flag, and the channel re-arms below hysteresis.
// FILTER selects whether a consecutive-fault filter qualifies the event.
module lim_temp_chan
    import lim_pkg::*;
#(
    parameter int W      = 8,
    parameter int CNT_W  = 2,
    parameter bit FILTER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic             clr_rd,
    input  logic [W-1:0]     rd,
    input  logic [W-1:0]     lim,
    input  logic [W-1:0]     hyst,
    input  logic [CNT_W-1:0] need_sel,
    input  logic             cmp_mode,
    output logic             flag_o
);

    logic  over;
    logic  hot;
    logic  cool;
    logic  armed_q;
    disc_e disc;

    // Raw limit tests and discipline decode.
    always_comb begin
        over = rd > lim;
        cool = sample_stb && (rd < hyst);
        disc = disc_of(cmp_mode);
    end

    generate
        if (FILTER) begin : g_filt
            lim_fault_filter #(.CNT_W(CNT_W)) u_filt (
                .clk       (clk),
                .rst_n     (rst_n),
                .sample_stb(sample_stb),
                .over      (over),
                .need_sel  (need_sel),
                .hot_o     (hot)
            );
        end else begin : g_direct
            logic unused_sel;
            // Unfiltered: any sampled over-limit reading qualifies.
            always_comb begin
                hot        = sample_stb && over;
                unused_sel = ^need_sel;
            end
        end
    endgenerate

    // Arming: cleared when an event fires, restored below hysteresis.
    always_ff @(posedge clk) begin
        if (!rst_n)              armed_q <= 1'b1;
        else if (hot && armed_q) armed_q <= 1'b0;
        else if (cool)           armed_q <= 1'b1;
    end

    // Flag update per discipline.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= 1'b0;
        else if (disc == DISC_CMP) begin
            if (hot)       flag_o <= 1'b1;
            else if (cool) flag_o <= 1'b0;
        end else begin
            if (hot && armed_q) flag_o <= 1'b1;
            else if (clr_rd)    flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/lim_irq_top.sv
// Limit interrupt mode logic top. Collects the voltage window flags and
// two temperature flags into a status vector. It drives the maskable
// interrupt from that vector and drives the over-temperature line from
// a second limit pair on sensor 2. Assumes readings are already
// converted and limits already decoded.
module lim_irq_top #(
    parameter int NUM_VOLT = 4,
    parameter int W        = 8,
    parameter int CNT_W    = 2,
    localparam int NS      = NUM_VOLT + 2,
    localparam int VW      = NUM_VOLT * W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic             stat_rd,
    input  logic [VW-1:0]    volt_rd,
    input  logic [VW-1:0]    volt_hi,
    input  logic [VW-1:0]    volt_lo,
    input  logic [W-1:0]     t1_rd,
    input  logic [W-1:0]     t1_hi,
    input  logic [W-1:0]     t1_hyst,
    input  logic [W-1:0]     t2_rd,
    input  logic [W-1:0]     t2_hi,
    input  logic [W-1:0]     t2_hyst,
    input  logic             t2_cmp_mode,
    input  logic [CNT_W-1:0] t2_fault_sel,
    input  logic [W-1:0]     ovt_lim,
    input  logic [W-1:0]     ovt_hyst,
    input  logic             ovt_cmp_mode,
    input  logic [NS-1:0]    smi_mask,
    output logic [NS-1:0]    stat_o,
    output logic             smi_o,
    output logic             ovt_o
);

    localparam logic [W-1:0] T1_CMP_CODE = W'((1 << (W - 1)) - 1);
    localparam int           IDX_T1      = NUM_VOLT;
    localparam int           IDX_T2      = NUM_VOLT + 1;

    logic t1_cmp;

    // Sensor 1 mode comes from its hysteresis code.
    always_comb t1_cmp = (t1_hyst == T1_CMP_CODE);

    generate
        for (genvar i = 0; i < NUM_VOLT; i++) begin : g_volt
            lim_volt_chan #(.W(W)) u_volt (
                .clk       (clk),
                .rst_n     (rst_n),
                .sample_stb(sample_stb),
                .clr_rd    (stat_rd),
                .rd        (volt_rd[i*W +: W]),
                .hi        (volt_hi[i*W +: W]),
                .lo        (volt_lo[i*W +: W]),
                .flag_o    (stat_o[i])
            );
        end
    endgenerate

    lim_temp_chan #(.W(W), .CNT_W(CNT_W), .FILTER(1'b0)) u_t1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_stb(sample_stb),
        .clr_rd    (stat_rd),
        .rd        (t1_rd),
        .lim       (t1_hi),
        .hyst      (t1_hyst),
        .need_sel  ('0),
        .cmp_mode  (t1_cmp),
        .flag_o    (stat_o[IDX_T1])
    );

    lim_temp_chan #(.W(W), .CNT_W(CNT_W), .FILTER(1'b1)) u_t2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_stb(sample_stb),
        .clr_rd    (stat_rd),
        .rd        (t2_rd),
        .lim       (t2_hi),
        .hyst      (t2_hyst),
        .need_sel  (t2_fault_sel),
        .cmp_mode  (t2_cmp_mode),
        .flag_o    (stat_o[IDX_T2])
    );

    lim_temp_chan #(.W(W), .CNT_W(CNT_W), .FILTER(1'b1)) u_ovt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_stb(sample_stb),
        .clr_rd    (stat_rd),
        .rd        (t2_rd),
        .lim       (ovt_lim),
        .hyst      (ovt_hyst),
        .need_sel  (t2_fault_sel),
        .cmp_mode  (ovt_cmp_mode),
        .flag_o    (ovt_o)
    );

    // Interrupt request from unmasked status.
    always_comb smi_o = |(stat_o & ~smi_mask);

endmodule

// File: rtl/lim_irq_chk.sv
// Checker for lim_irq_top: temporal properties on the top's ports.
// It is attached with the bind below.
module lim_irq_chk #(
    parameter int NUM_VOLT = 4,
    parameter int W        = 8,
    parameter int CNT_W    = 2,
    localparam int NS      = NUM_VOLT + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_stb,
    input logic          stat_rd,
    input logic [W-1:0]  t1_hyst,
    input logic [NS-1:0] smi_mask,
    input logic [NS-1:0] stat_o,
    input logic          smi_o,
    input logic          ovt_o
);

    localparam logic [W-1:0] CMP_CODE = W'((1 << (W - 1)) - 1);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (stat_o == '0 && !ovt_o));

    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_stb && !stat_rd) |=> ($stable(stat_o) && $stable(ovt_o)));

    a_r4_cmp_ignores_read: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_hyst == CMP_CODE && stat_rd && !sample_stb) |=> $stable(stat_o[NUM_VOLT]));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_hyst != CMP_CODE && stat_rd && !sample_stb) |=> !stat_o[NUM_VOLT]);

    a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&smi_mask) |-> !smi_o);

    generate
        for (genvar i = 0; i < NUM_VOLT; i++) begin : g_v
            a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (stat_o[i] && !stat_rd) |=> stat_o[i]);
            a_r2_set_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(stat_o[i]) |-> $past(sample_stb));
        end
    endgenerate

endmodule

bind lim_irq_top lim_irq_chk #(.NUM_VOLT(NUM_VOLT), .W(W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_stb(sample_stb),
    .stat_rd   (stat_rd),
    .t1_hyst   (t1_hyst),
    .smi_mask  (smi_mask),
    .stat_o    (stat_o),
    .smi_o     (smi_o),
    .ovt_o     (ovt_o)
);

// File: tb/lim_irq_top_test.sv
// Bench for lim_irq_top: vector table walk, then directed tests.
module lim_irq_top_test;

    localparam int NV = 2;
    localparam int W  = 8;
    localparam int CW = 2;
    localparam int NS = NV + 2;
    localparam int IT1 = NV;
    localparam int IT2 = NV + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sample_stb = 1'b0;
    logic            stat_rd = 1'b0;
    logic [W-1:0]    v0 = 8'd100, v1 = 8'd100;
    logic [NV*W-1:0] volt_hi, volt_lo;
    logic [W-1:0]    t1_rd = 8'd20, t1_hi = 8'd80, t1_hyst = 8'd70;
    logic [W-1:0]    t2_rd = 8'd50, t2_hi = 8'd90, t2_hyst = 8'd80;
    logic            t2_cmp_mode = 1'b0;
    logic [CW-1:0]   t2_fault_sel = 2'd1;
    logic [W-1:0]    ovt_lim = 8'd120, ovt_hyst = 8'd100;
    logic            ovt_cmp_mode = 1'b1;
    logic [NS-1:0]   smi_mask = '0;
    logic [NS-1:0]   stat_o;
    logic            smi_o, ovt_o;

    int n_run = 0;
    int n_fail = 0;

    assign volt_hi = {8'd200, 8'd200};
    assign volt_lo = {8'd50, 8'd50};

    always #4 clk = ~clk;

    lim_irq_top #(.NUM_VOLT(NV), .W(W), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .stat_rd(stat_rd),
        .volt_rd({v1, v0}), .volt_hi(volt_hi), .volt_lo(volt_lo),
        .t1_rd(t1_rd), .t1_hi(t1_hi), .t1_hyst(t1_hyst),
        .t2_rd(t2_rd), .t2_hi(t2_hi), .t2_hyst(t2_hyst),
        .t2_cmp_mode(t2_cmp_mode), .t2_fault_sel(t2_fault_sel),
        .ovt_lim(ovt_lim), .ovt_hyst(ovt_hyst), .ovt_cmp_mode(ovt_cmp_mode),
        .smi_mask(smi_mask), .stat_o(stat_o), .smi_o(smi_o), .ovt_o(ovt_o)
    );

    // Row: {sample, read, v0, t2, exp v0 bit, exp t2 bit, exp ovt}
    localparam logic [20:0] VEC [14] = '{
        {1'b1, 1'b0, 8'd100, 8'd50,  3'b000},
        {1'b1, 1'b0, 8'd201, 8'd95,  3'b100},
        {1'b1, 1'b0, 8'd100, 8'd95,  3'b110},
        {1'b0, 1'b1, 8'd100, 8'd95,  3'b000},
        {1'b1, 1'b0, 8'd49,  8'd95,  3'b100},
        {1'b0, 1'b1, 8'd100, 8'd95,  3'b000},
        {1'b1, 1'b0, 8'd50,  8'd85,  3'b000},
        {1'b1, 1'b0, 8'd200, 8'd79,  3'b000},
        {1'b1, 1'b0, 8'd200, 8'd125, 3'b000},
        {1'b1, 1'b0, 8'd200, 8'd125, 3'b011},
        {1'b0, 1'b1, 8'd200, 8'd125, 3'b001},
        {1'b1, 1'b0, 8'd200, 8'd110, 3'b001},
        {1'b1, 1'b0, 8'd200, 8'd99,  3'b000},
        {1'b1, 1'b1, 8'd255, 8'd99,  3'b100}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic smp, input logic rd);
        sample_stb = smp;
        stat_rd    = rd;
        tick();
        sample_stb = 1'b0;
        stat_rd    = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 stat", 32'(stat_o), 0);
        chk("R1 smi", 32'(smi_o), 0);
        chk("R1 ovt", 32'(ovt_o), 0);

        // Table walk: voltage ch0, sensor 2 interrupt mode (2 faults), ovt comparator.
        for (int k = 0; k < 14; k++) begin
            v0    = VEC[k][18:11];
            t2_rd = VEC[k][10:3];
            pulse(VEC[k][20], VEC[k][19]);
            chk($sformatf("R2/R3 row%0d v0", k), 32'(stat_o[0]), 32'(VEC[k][2]));
            chk($sformatf("R7/R8 row%0d t2", k), 32'(stat_o[IT2]), 32'(VEC[k][1]));
            chk($sformatf("R9 row%0d ovt", k), 32'(ovt_o), 32'(VEC[k][0]));
        end

        // R4: sensor 1 comparator mode via hysteresis code 127.
        do_reset();
        v0 = 8'd100; t2_rd = 8'd50;
        t1_hyst = 8'd127; t1_rd = 8'd90;
        pulse(1'b1, 1'b0);
        chk("R4 set", 32'(stat_o[IT1]), 1);
        pulse(1'b0, 1'b1);
        chk("R4 read ignored", 32'(stat_o[IT1]), 1);
        t1_rd = 8'd80;
        pulse(1'b1, 1'b0);
        chk("R4 clear at limit", 32'(stat_o[IT1]), 0);

        // R5: sensor 1 interrupt mode.
        t1_hyst = 8'd70; t1_rd = 8'd90;
        pulse(1'b1, 1'b0);
        chk("R5 set", 32'(stat_o[IT1]), 1);
        pulse(1'b0, 1'b1);
        chk("R5 read clears", 32'(stat_o[IT1]), 0);
        pulse(1'b1, 1'b0);
        chk("R5 not rearmed", 32'(stat_o[IT1]), 0);
        t1_rd = 8'd60;
        pulse(1'b1, 1'b0);
        chk("R5 below hyst", 32'(stat_o[IT1]), 0);
        t1_rd = 8'd90;
        pulse(1'b1, 1'b0);
        chk("R5 rearmed set", 32'(stat_o[IT1]), 1);

        // R6: sensor 2 comparator mode, single fault.
        do_reset();
        t1_rd = 8'd20;
        t2_cmp_mode = 1'b1; t2_fault_sel = 2'd0; t2_rd = 8'd95;
        pulse(1'b1, 1'b0);
        chk("R6 set", 32'(stat_o[IT2]), 1);
        pulse(1'b0, 1'b1);
        chk("R6 read ignored", 32'(stat_o[IT2]), 1);
        t2_rd = 8'd85;
        pulse(1'b1, 1'b0);
        chk("R6 hold in band", 32'(stat_o[IT2]), 1);
        t2_rd = 8'd79;
        pulse(1'b1, 1'b0);
        chk("R6 clear below hyst", 32'(stat_o[IT2]), 0);

        // R8: four consecutive faults needed; a clean sample restarts.
        t2_fault_sel = 2'd3; t2_rd = 8'd95;
        for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0);
        chk("R8 three faults", 32'(stat_o[IT2]), 0);
        t2_rd = 8'd85;
        pulse(1'b1, 1'b0);
        t2_rd = 8'd95;
        for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0);
        chk("R8 restart count", 32'(stat_o[IT2]), 0);
        pulse(1'b1, 1'b0);
        chk("R8 fourth fault", 32'(stat_o[IT2]), 1);

        // R10: masking.
        do_reset();
        t2_rd = 8'd50; v1 = 8'd10;
        pulse(1'b1, 1'b0);
        chk("R10 status", 32'(stat_o), 32'h2);
        chk("R10 smi on", 32'(smi_o), 1);
        smi_mask = 4'b0010;
        #1;
        chk("R10 masked smi", 32'(smi_o), 0);
        chk("R10 stat unaffected", 32'(stat_o), 32'h2);
        smi_mask = '0; v1 = 8'd100;

        // R11 and R9 interrupt mode: readings without strobe are ignored.
        do_reset();
        ovt_cmp_mode = 1'b0; t2_fault_sel = 2'd0; t2_cmp_mode = 1'b0;
        t2_rd = 8'd130; v0 = 8'd255;
        tick();
        tick();
        chk("R11 no strobe ovt", 32'(ovt_o), 0);
        chk("R11 no strobe stat", 32'(stat_o), 0);
        pulse(1'b1, 1'b0);
        chk("R9 ovt intr set", 32'(ovt_o), 1);
        pulse(1'b0, 1'b1);
        chk("R9 ovt intr read clears", 32'(ovt_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule